// File: doc/BRIEF.md
# Edge-Qualified Pin and Watchdog Interrupt Generator

This block turns activity on four general-purpose pins and a watchdog timeout into sticky status flags and a single open-drain, active-low interrupt request. It takes the pin levels, which must already be synchronized, and the configuration register contents for each pin: direction, interrupt enable and edge polarity. A pin event is recorded only when all three settings allow it.

Software clears the flags with one-cycle write-one-to-clear strobes. A global output-disable bit keeps the interrupt line released, but it leaves the flags themselves untouched. A watchdog timeout strobe sets a separate flag, and only while the watchdog is enabled. The register bus and the watchdog counter live outside this block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, with no event since, all pin flags and the watchdog flag read 0 and irq_pull_o is 0 (line released).
- R2: A pin edge is found by comparing pin_i with its value sampled one clock earlier. With edge_sel_i bit 1 a rising edge qualifies, and with bit 0 a falling edge qualifies. The opposite edge sets nothing.
- R3: A pin can set its flag only while its dir_in_i bit is 1 (input). A bit of 0 (output) suppresses all events on that pin.
- R4: A pin can set its flag only while its irq_en_i bit is 1. A bit of 0 masks the pin.
- R5: A qualifying edge presented before a clock edge sets that pin's bit of pin_flag_o at that clock edge. Pins are independent, and bit k of every vector belongs to pin k.
- R6: A flag stays set until its clear strobe is high at a clock edge, and that edge clears it.
- R7: If a set event and a clear strobe for the same flag meet at one clock edge, the flag is 1 after the edge.
- R8: wdt_timeout_i high at a clock edge sets wdt_flag_o only while wdt_en_i is 1. It has no effect while wdt_en_i is 0.
- R9: irq_pull_o is 1 (drive line low) exactly when any pin flag or the watchdog flag is set and out_dis_i is 0. When out_dis_i is 1, irq_pull_o is 0 and the flags are unaffected.
- R10: The pin level present when reset ends is not treated as an edge. The first clock after reset only records the pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Synchronized pin levels |
| dir_in_i | input | 4 | Per-pin direction, 1 = input |
| irq_en_i | input | 4 | Per-pin interrupt enable (mask) |
| edge_sel_i | input | 4 | Per-pin edge select, 1 = rising, 0 = falling |
| pin_clr_i | input | 4 | Write-one-to-clear strobes for pin flags |
| wdt_en_i | input | 1 | Watchdog enable |
| wdt_timeout_i | input | 1 | Watchdog timeout strobe |
| wdt_clr_i | input | 1 | Clear strobe for the watchdog flag |
| out_dis_i | input | 1 | Global interrupt output disable, 1 = released |
| pin_flag_o | output | 4 | Pin interrupt status flags |
| wdt_flag_o | output | 1 | Watchdog interrupt status flag |
| irq_pull_o | output | 1 | Pull-down enable for the open-drain interrupt line |

## Verification
A stale previous-level register shows up as a wrong or missing flag one cycle after a pin changes. A missing armed bit shows up as a spurious flag in the first cycle after reset. A flag register that loses its hold path, or that lets a clear win over a set, reads wrong on the cycle after the strobe. Because irq_pull_o is derived directly from the flags, any bad flag also shows on the interrupt line in that same cycle unless out_dis_i hides it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NUM_PINS = 4;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = NUM_PINS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] dir_in_i,
  input  logic [WIDTH-1:0] irq_en_i,
  input  logic [WIDTH-1:0] edge_sel_i,
  output logic [WIDTH-1:0] evt_o
);
  logic [WIDTH-1:0] level_q;
  logic             armed_q;

  // armed_q blocks the first compare after reset (level at release is no edge)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      armed_q <= 1'b0;
    end else begin
      level_q <= level_i;
      armed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    edge_sel_e sel;
    logic      rise, fall, hit;
    always_comb begin
      sel   = edge_sel_e'(edge_sel_i[g]);
      rise  = level_i[g] & ~level_q[g];
      fall  = ~level_i[g] & level_q[g];
      hit   = (sel == EDGE_RISE) ? rise : fall;
      evt_o[g] = armed_q & dir_in_i[g] & irq_en_i[g] & hit;
    end
  end
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chk
    a_r6_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[g] && !clr_i[g] |=> flag_o[g]);
    a_r6_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] && !set_i[g] |=> !flag_o[g]);
    a_r7_set_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = NUM_PINS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] pin_i,
  input  logic [PINS-1:0] dir_in_i,
  input  logic [PINS-1:0] irq_en_i,
  input  logic [PINS-1:0] edge_sel_i,
  input  logic [PINS-1:0] pin_clr_i,
  input  logic            wdt_en_i,
  input  logic            wdt_timeout_i,
  input  logic            wdt_clr_i,
  input  logic            out_dis_i,
  output logic [PINS-1:0] pin_flag_o,
  output logic            wdt_flag_o,
  output logic            irq_pull_o
);
  logic [PINS-1:0] pin_evt;
  logic            wdt_evt;
  logic            any_flag;

  gpio_irq_edge #(.WIDTH(PINS)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (pin_i),
    .dir_in_i   (dir_in_i),
    .irq_en_i   (irq_en_i),
    .edge_sel_i (edge_sel_i),
    .evt_o      (pin_evt)
  );

  gpio_irq_flags #(.WIDTH(PINS)) u_pin_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pin_evt),
    .clr_i  (pin_clr_i),
    .flag_o (pin_flag_o)
  );

  assign wdt_evt = wdt_timeout_i & wdt_en_i;

  gpio_irq_flags #(.WIDTH(1)) u_wdt_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wdt_evt),
    .clr_i  (wdt_clr_i),
    .flag_o (wdt_flag_o)
  );

  assign any_flag   = (|pin_flag_o) | wdt_flag_o;
  assign irq_pull_o = any_flag & ~out_dis_i;

  a_r9_released : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_dis_i |-> !irq_pull_o);
  a_r9_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_flag_o == '0) && !wdt_flag_o |-> !irq_pull_o);
  a_r8_wdt_gate : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_flag_o) |-> $past(wdt_en_i && wdt_timeout_i));

  for (genvar g = 0; g < PINS; g++) begin : g_chk
    a_r3_r4_qualified : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pin_flag_o[g]) |-> $past(dir_in_i[g] && irq_en_i[g]));
    a_r2_edge_seen : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pin_flag_o[g]) |-> $past(pin_i[g]) != $past(pin_i[g], 2));
  end
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pin_i = '0, dir_in_i = '0, irq_en_i = '0, edge_sel_i = '0, pin_clr_i = '0;
  logic       wdt_en_i = 1'b0, wdt_timeout_i = 1'b0, wdt_clr_i = 1'b0, out_dis_i = 1'b0;
  logic [3:0] pin_flag_o;
  logic       wdt_flag_o, irq_pull_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_irq_ctrl u_dut (
    .clk_i, .rst_ni, .pin_i, .dir_in_i, .irq_en_i, .edge_sel_i, .pin_clr_i,
    .wdt_en_i, .wdt_timeout_i, .wdt_clr_i, .out_dis_i,
    .pin_flag_o, .wdt_flag_o, .irq_pull_o
  );

  // {dir, en, edge_sel, start level, end level, expected flags}
  localparam logic [23:0] VEC [8] = '{
    {4'hF, 4'hF, 4'hF, 4'h0, 4'hF, 4'hF}, // R2 rising
    {4'hF, 4'hF, 4'h0, 4'hF, 4'h0, 4'hF}, // R2 falling
    {4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0}, // R2 wrong edge
    {4'h0, 4'hF, 4'hF, 4'h0, 4'hF, 4'h0}, // R3 outputs
    {4'hF, 4'h0, 4'hF, 4'h0, 4'hF, 4'h0}, // R4 masked
    {4'hA, 4'hF, 4'hF, 4'h0, 4'hF, 4'hA}, // R3 mixed dir
    {4'hF, 4'h5, 4'h3, 4'h0, 4'hF, 4'h1}, // R4/R5 mixed
    {4'hF, 4'hF, 4'hC, 4'h5, 4'hA, 4'h9}  // R5 per-pin edges
  };

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_all();
    pin_clr_i = '1; wdt_clr_i = 1'b1;
    @(negedge clk_i);
    pin_clr_i = '0; wdt_clr_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 during reset, R10 pin high across release
    pin_i = 4'hF; dir_in_i = 4'hF; irq_en_i = 4'hF; edge_sel_i = 4'hF;
    repeat (3) @(negedge clk_i);
    check("R1 flags in reset", pin_flag_o, 4'h0);
    check("R1 pull in reset", {3'b0, irq_pull_o}, 4'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R10 no edge at release", pin_flag_o, 4'h0);
    check("R1 wdt flag", {3'b0, wdt_flag_o}, 4'h0);

    for (int i = 0; i < 8; i++) begin
      dir_in_i = VEC[i][23:20]; irq_en_i = VEC[i][19:16]; edge_sel_i = VEC[i][15:12];
      pin_i = VEC[i][11:8];
      repeat (2) @(negedge clk_i);
      clear_all();
      pin_i = VEC[i][7:4];
      @(negedge clk_i);
      check($sformatf("R2/R3/R4/R5 vec %0d", i), pin_flag_o, VEC[i][3:0]);
      check($sformatf("R9 pull vec %0d", i), {3'b0, irq_pull_o}, {3'b0, VEC[i][3:0] != 4'h0});
    end

    // R6 sticky then cleared
    dir_in_i = 4'hF; irq_en_i = 4'hF; edge_sel_i = 4'hF; pin_i = 4'h0;
    repeat (2) @(negedge clk_i);
    clear_all();
    pin_i = 4'h2;
    repeat (5) @(negedge clk_i);
    check("R6 sticky", pin_flag_o, 4'h2);
    pin_clr_i = 4'h2;
    @(negedge clk_i);
    pin_clr_i = 4'h0;
    check("R6 cleared", pin_flag_o, 4'h0);

    // R7 set and clear at the same edge
    pin_i = 4'h6; pin_clr_i = 4'h4;
    @(negedge clk_i);
    pin_clr_i = 4'h0;
    check("R7 set wins", pin_flag_o, 4'h4);

    // R9 output disable hides the line, not the flags
    out_dis_i = 1'b1;
    @(negedge clk_i);
    check("R9 disabled pull", {3'b0, irq_pull_o}, 4'h0);
    check("R9 flags kept", pin_flag_o, 4'h4);
    out_dis_i = 1'b0;
    @(negedge clk_i);
    check("R9 enabled pull", {3'b0, irq_pull_o}, 4'h1);
    clear_all();

    // R8 watchdog
    wdt_en_i = 1'b0; wdt_timeout_i = 1'b1;
    @(negedge clk_i);
    wdt_timeout_i = 1'b0;
    check("R8 wdt disabled", {3'b0, wdt_flag_o}, 4'h0);
    check("R8 pull idle", {3'b0, irq_pull_o}, 4'h0);
    wdt_en_i = 1'b1; wdt_timeout_i = 1'b1;
    @(negedge clk_i);
    wdt_timeout_i = 1'b0;
    check("R8 wdt set", {3'b0, wdt_flag_o}, 4'h1);
    check("R9 wdt pull", {3'b0, irq_pull_o}, 4'h1);
    check("R8 pins untouched", pin_flag_o, 4'h0);
    clear_all();
    check("R6 wdt cleared", {3'b0, wdt_flag_o}, 4'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule